// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block chooses which of two programmable charge-pump current codes a frequency synthesizer uses. Software shifts a 24-bit word in serially, most significant bit first, then pulses a load strobe. The two lowest bits of the word pick its target. One target is the configuration latch, which holds both current codes, a fastlock enable, an exit-mode bit and a 4-bit timeout field. The other target is the divider latch, which holds the boost (gain) bit.

When fastlock is enabled and the gain bit is 1, the block drives the boost current code. Otherwise it drives the steady-state code. In manual exit mode the boost lasts until software writes the gain bit back to 0. In timed exit mode a counter advances on each phase-detector cycle pulse. After 3 + 4×timeout cycles it clears the gain bit by itself, and the steady code returns.

Top module: `cp_boost_ctrl`

## Requirements
- R1: After reset, `cp_code` is 0 and `gain_bit` is 0.
- R2: A loaded word whose bits [1:0] are 2'b10 writes the configuration latch. Its fields are: steady code in bits [17:15], boost code in bits [20:18], timeout in bits [14:11], exit mode in bit 10 (0 = manual, 1 = timed) and fastlock enable in bit 9.
- R3: A loaded word whose bits [1:0] are 2'b01 writes the divider latch, and `gain_bit` takes the value of its bit 21. The gain bit rises only through such a write.
- R4: A loaded word whose bits [1:0] are 2'b00 or 2'b11 changes neither `cp_code` nor `gain_bit`.
- R5: When the enable bit is 0, `cp_code` equals the steady code, whatever the gain bit holds.
- R6: When the enable bit is 1 and the gain bit is 1, `cp_code` equals the boost code.
- R7: In manual mode the gain bit stays 1 whatever the `pd_tick` pulses do, until a divider write clears it.
- R8: In timed mode with enable set, the gain bit is written to 1 and then clears on the (3 + 4×timeout)-th `pd_tick` pulse. After that, `cp_code` returns to the steady code.
- R9: Writing the gain bit to 1 again while the timer runs restarts the full timeout.
- R10: Bits shift in on `ser_shift`, the first bit becoming word bit 23. A `ser_load` pulse sampled at clock edge k makes the new latch contents visible after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial data bit |
| ser_shift | input | 1 | Shifts `ser_data` into the word register |
| ser_load | input | 1 | Transfers the assembled word to its latch |
| pd_tick | input | 1 | One pulse per phase-detector cycle |
| cp_code | output | 3 | Active charge-pump current code |
| gain_bit | output | 1 | Current value of the divider-latch gain bit |

## Verification
The bench builds the block with its default widths: a 24-bit word, 3-bit current codes and a 4-bit timeout. With these widths both ends of the timeout range can be reached, the 3-cycle window at timeout 0 and the 63-cycle window at timeout 15, and the timer count never exceeds its 6-bit width. It checks the gain bit one tick before and exactly at expiry. It also rewrites the gain bit mid-count to show the restart, and it loads words with asymmetric current codes so that a reversed shift order or a one-cycle latency slip shows up at the outputs.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int WORD_W    = 24;
    localparam int CODE_W    = 3;
    localparam int TC_W      = 4;
    localparam int CNT_W     = TC_W + 2;

    localparam logic [1:0] SEL_CFG = 2'b10;
    localparam logic [1:0] SEL_DIV = 2'b01;

    localparam int EN_POS    = 9;
    localparam int MODE_POS  = 10;
    localparam int TC_LSB    = 11;
    localparam int STEADY_LSB = 15;
    localparam int BOOST_LSB = 18;
    localparam int GAIN_POS  = 21;

    typedef struct packed {
        logic [CODE_W-1:0] boost;
        logic [CODE_W-1:0] steady;
        logic [TC_W-1:0]   tc;
        logic              timed;
        logic              en;
    } cfg_t;
endpackage

// File: rtl/cbc_shifter.sv
module cbc_shifter
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_shift,
    input  logic              ser_load,
    output logic [WORD_W-1:0] word,
    output logic              word_vld
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] word;
        logic              vld;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.vld = 1'b0;
        if (ser_shift) begin
            sh_d.sr = {sh_q.sr[WORD_W-2:0], ser_data};
        end
        if (ser_load) begin
            sh_d.word = sh_q.sr;
            sh_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word     = sh_q.word;
    assign word_vld = sh_q.vld;
endmodule

// File: rtl/cbc_latches.sv
module cbc_latches
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              word_vld,
    input  logic              expire,
    output cfg_t              cfg,
    output logic              gain,
    output logic              div_wr,
    output logic              tmr_start,
    output logic              tmr_stop
);
    typedef struct packed {
        cfg_t cfg;
        logic gain;
    } lt_t;

    lt_t  lt_d, lt_q;
    logic cfg_wr;
    cfg_t cfg_new;

    always_comb begin
        cfg_wr         = word_vld && (word[1:0] == SEL_CFG);
        div_wr         = word_vld && (word[1:0] == SEL_DIV);
        cfg_new.boost  = word[BOOST_LSB +: CODE_W];
        cfg_new.steady = word[STEADY_LSB +: CODE_W];
        cfg_new.tc     = word[TC_LSB +: TC_W];
        cfg_new.timed  = word[MODE_POS];
        cfg_new.en     = word[EN_POS];

        lt_d = lt_q;
        if (cfg_wr) lt_d.cfg = cfg_new;
        if (div_wr)      lt_d.gain = word[GAIN_POS];
        else if (expire) lt_d.gain = 1'b0;

        tmr_start = div_wr && word[GAIN_POS] && lt_q.cfg.en && lt_q.cfg.timed;
        if (div_wr)      tmr_stop = !tmr_start;
        else if (cfg_wr) tmr_stop = !(cfg_new.en && cfg_new.timed);
        else             tmr_stop = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign cfg  = lt_q.cfg;
    assign gain = lt_q.gain;
endmodule

// File: rtl/cbc_timer.sv
module cbc_timer
    import cbc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d   = tm_q;
        expire = 1'b0;
        if (start) begin
            tm_d.cnt = {tc, 2'b11};
        end else if (stop) begin
            tm_d.cnt = '0;
        end else if (tick && tm_q.cnt != '0) begin
            tm_d.cnt = tm_q.cnt - 1'b1;
            expire   = (tm_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end
endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_shift,
    input  logic              ser_load,
    input  logic              pd_tick,
    output logic [CODE_W-1:0] cp_code,
    output logic              gain_bit
);
    logic [WORD_W-1:0] word;
    logic              word_vld;
    logic              expire;
    cfg_t              cfg;
    logic              gain;
    logic              div_wr;
    logic              tmr_start;
    logic              tmr_stop;

    cbc_shifter u_sh (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_shift(ser_shift),
        .ser_load(ser_load), .word(word), .word_vld(word_vld)
    );

    cbc_latches u_lt (
        .clk(clk), .rst_n(rst_n), .word(word), .word_vld(word_vld),
        .expire(expire), .cfg(cfg), .gain(gain), .div_wr(div_wr),
        .tmr_start(tmr_start), .tmr_stop(tmr_stop)
    );

    cbc_timer u_tm (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .stop(tmr_stop),
        .tick(pd_tick), .tc(cfg.tc), .expire(expire)
    );

    always_comb begin
        cp_code  = (cfg.en && gain) ? cfg.boost : cfg.steady;
        gain_bit = gain;
    end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
    import cbc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] cp_code,
    input logic              gain_bit,
    input logic              pd_tick,
    input logic              div_wr,
    input logic              word_vld,
    input logic [1:0]        word_sel,
    input logic              word_gain,
    input logic              expire,
    input logic              en_q,
    input logic              timed_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cp_code == '0 && !gain_bit));

    assert_rise_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_bit) |-> $past(div_wr));

    assert_ignored_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (word_sel == 2'b00 || word_sel == 2'b11) && !expire)
        |=> ($stable(gain_bit) && $stable(cp_code)));

    assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_bit && !timed_q && !div_wr) |=> gain_bit);

    assert_timed_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gain_bit) && !$past(div_wr)) |-> ($past(pd_tick) && $past(timed_q) && $past(en_q)));

    assert_restart_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_wr && word_gain && en_q && timed_q) |=> gain_bit);
endmodule

bind cp_boost_ctrl cbc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cp_code(cp_code), .gain_bit(gain_bit),
    .pd_tick(pd_tick), .div_wr(div_wr), .word_vld(word_vld),
    .word_sel(word[1:0]), .word_gain(word[cbc_pkg::GAIN_POS]), .expire(expire),
    .en_q(cfg.en), .timed_q(cfg.timed)
);

// File: tb/sim_cp_boost_ctrl.sv
module sim_cp_boost_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_shift = 1'b0;
    logic       ser_load = 1'b0;
    logic       pd_tick = 1'b0;
    logic [2:0] cp_code;
    logic       gain_bit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] code;
        logic       gain;
        string      req;
    } exp_t;

    exp_t sbq[$];

    always #2.5 clk = ~clk;

    cp_boost_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_shift(ser_shift),
        .ser_load(ser_load), .pd_tick(pd_tick), .cp_code(cp_code), .gain_bit(gain_bit)
    );

    function automatic void compare(logic [2:0] code, logic gain, string req);
        checks++;
        if (cp_code !== code || gain_bit !== gain) begin
            failures++;
            $display("FAIL %s: code=%0d gain=%0d expected code=%0d gain=%0d",
                     req, cp_code, gain_bit, code, gain);
        end
    endfunction

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            compare(e.code, e.gain, e.req);
        end
    end

    task automatic expect_state(logic [2:0] code, logic gain, string req);
        exp_t e;
        e.code = code; e.gain = gain; e.req = req;
        sbq.push_back(e);
        wait (sbq.size() == 0);
        @(negedge clk);
    endtask

    function automatic logic [23:0] cfg_word(logic [2:0] steady, logic [2:0] boost,
                                             logic [3:0] tc, logic timed, logic en);
        logic [23:0] w = '0;
        w[20:18] = boost; w[17:15] = steady; w[14:11] = tc;
        w[10] = timed; w[9] = en; w[1:0] = 2'b10;
        return w;
    endfunction

    function automatic logic [23:0] div_word(logic g, logic [1:0] sel);
        logic [23:0] w = '0;
        w[20:2] = 19'h2D2D3;
        w[21] = g; w[1:0] = sel;
        return w;
    endfunction

    task automatic shift_in(logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk);
            ser_data = w[i]; ser_shift = 1'b1;
        end
        @(negedge clk);
        ser_shift = 1'b0; ser_load = 1'b1;
        @(negedge clk);
        ser_load = 1'b0;
    endtask

    task automatic load(logic [23:0] w);
        shift_in(w);
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pd_tick = 1'b1;
            @(negedge clk); pd_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state(3'd0, 1'b0, "R1 reset state");

        load(cfg_word(3'd2, 3'd5, 4'd0, 1'b0, 1'b0));
        expect_state(3'd2, 1'b0, "R2 config write, disabled");
        load(div_word(1'b1, 2'b01));
        expect_state(3'd2, 1'b1, "R5 gain set while disabled");
        load(cfg_word(3'd2, 3'd5, 4'd0, 1'b0, 1'b1));
        expect_state(3'd5, 1'b1, "R6 enable with gain set");
        ticks(80);
        expect_state(3'd5, 1'b1, "R7 manual mode ignores ticks");
        load(div_word(1'b0, 2'b01));
        expect_state(3'd2, 1'b0, "R3 R7 gain cleared by write");

        load(div_word(1'b1, 2'b00));
        expect_state(3'd2, 1'b0, "R4 select 00 ignored");
        load(cfg_word(3'd7, 3'd7, 4'd3, 1'b1, 1'b0) | 24'h200001);
        expect_state(3'd2, 1'b0, "R4 select 11 ignored");

        load(cfg_word(3'd2, 3'd5, 4'd0, 1'b1, 1'b1));
        load(div_word(1'b1, 2'b01));
        expect_state(3'd5, 1'b1, "R6 timed boost entered");
        ticks(2);
        expect_state(3'd5, 1'b1, "R8 tc0 one tick before expiry");
        ticks(1);
        expect_state(3'd2, 1'b0, "R8 tc0 expires at tick 3");

        load(cfg_word(3'd2, 3'd5, 4'd15, 1'b1, 1'b1));
        load(div_word(1'b1, 2'b01));
        ticks(62);
        expect_state(3'd5, 1'b1, "R8 tc15 before expiry");
        ticks(1);
        expect_state(3'd2, 1'b0, "R8 tc15 expires at tick 63");

        load(cfg_word(3'd2, 3'd5, 4'd1, 1'b1, 1'b1));
        load(div_word(1'b1, 2'b01));
        ticks(5);
        load(div_word(1'b1, 2'b01));
        ticks(5);
        expect_state(3'd5, 1'b1, "R9 restart extends boost");
        ticks(2);
        expect_state(3'd2, 1'b0, "R9 expiry after full restart");

        shift_in(cfg_word(3'd1, 3'd6, 4'd0, 1'b0, 1'b1));
        compare(3'd2, 1'b0, "R10 old value one edge after load");
        @(negedge clk);
        compare(3'd1, 1'b0, "R10 new steady code, MSB first");
        load(div_word(1'b1, 2'b01));
        expect_state(3'd6, 1'b1, "R10 new boost code");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule